// File: doc/BRIEF.md
# SPI Master Transmit Path

This block is the outgoing half of an SPI master. Software hands it bytes through a one-byte write port. The bytes are shifted out on a serial data line, most significant bit first, against a serial clock. That clock comes from a programmable divider of the system clock. Chip-select handling and the receive side are not part of the block.

Two buffering modes are available. In single mode a one-byte holding register feeds the shift register directly. An empty request pulses each time that register is moved into the shifter, so software can supply the next byte. In sequential mode the bytes go into a 32-entry FIFO instead. The empty request then pulses when the free space in the FIFO climbs to a selectable threshold, either half the FIFO or all of it. Software is expected to refill the FIFO in blocks of 16 bytes. A transmit-end request pulses once the final bit clock of the last byte has completed and nothing is left to send.

Each request appears as a one-cycle pulse and also sets a sticky status bit. A third sticky bit records a write that was dropped. Software clears the sticky bits with a write-one-to-clear strobe.

Top module: `spi_tx_core`

## Requirements
- R1: After synchronous reset, sclk equals cpol, mosi is 0, both request pulses are 0 and all three status bits are 0.
- R2: Each byte is shifted out MSB first, 8 bits per byte. Every high and low phase of sclk within a byte lasts clk_div+1 system clock cycles. mosi changes only on trailing edges, so it is stable at each leading edge (the edge away from the idle level).
- R3: With seq_mode=0, a byte in the holding register moves into the shifter when the shifter is idle and start=1. irq_empty pulses exactly once for every such move.
- R4: With seq_mode=0, a write arriving while the holding register is still occupied is dropped (that byte is never sent) and sets status bit 2.
- R5: With seq_mode=1, bytes written to the FIFO are sent in write order. The FIFO holds 32 bytes.
- R6: With seq_mode=1 and thr_sel=0, irq_empty pulses when a byte leaving the FIFO raises its free space to exactly 16.
- R7: With seq_mode=1 and thr_sel=1, irq_empty pulses when a byte leaving the FIFO raises its free space to exactly 32 (FIFO drained).
- R8: With seq_mode=1, a write while the FIFO holds 32 bytes is dropped and sets status bit 2. The FIFO count never exceeds 32.
- R9: irq_end pulses once a byte's final trailing sclk edge has occurred with no byte waiting in the active source. That edge is falling for cpol=0 and rising for cpol=1. sclk then rests at the cpol level.
- R10: While start=0, no new byte is moved into the shifter: sclk stays at its idle level and irq_empty stays low.
- R11: Status bit 0 is set by irq_empty, bit 1 by irq_end and bit 2 by a dropped write. A bit stays set until a 1 in the matching stat_clr position clears it.
- R12: irq_empty and irq_end are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| seq_mode | input | 1 | 0 = single register mode, 1 = sequential FIFO mode |
| thr_sel | input | 1 | Sequential empty threshold: 0 = 16 free, 1 = 32 free |
| cpol | input | 1 | Serial clock idle level |
| start | input | 1 | Enables moving new bytes into the shifter |
| clk_div | input | 8 | Half bit period minus one, in system clocks |
| stat_clr | input | 3 | Write-one-to-clear strobes for the status bits |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| irq_empty | output | 1 | Empty request pulse |
| irq_end | output | 1 | Transmit-end request pulse |
| status | output | 3 | Sticky bits: 0 empty, 1 end, 2 dropped write |

## Verification
The bench fills the FIFO completely, overfills it by one byte, and refills it by 16 after the first threshold pulse. A design that counted free space wrongly would pulse a different number of times, and one that let the extra byte in would emit a byte nobody expects. A write to an occupied single-mode register is checked to be dropped; a design that overwrote the register would send the wrong byte. Transmit-end timing is checked under both clock polarities, and so are the phase lengths for divider values down to 0. A design that flagged the end one edge early, or ended a byte on the wrong edge, would show bits still pending or sclk away from its idle level when the pulse arrives. Random rounds also use a 16-byte fill against the half threshold. That fill must produce no empty pulse, which catches a level compare used where an upward crossing is required.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

    localparam int BYTE_W     = 8;
    localparam int FIFO_DEPTH = 32;
    localparam int CLK_DIV_W  = 8;
    localparam int STAT_N     = 3;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_SEQ    = 1'b1
    } tx_mode_e;

    // Packed so that bit 0 = empty, bit 1 = end, bit 2 = dropped write.
    typedef struct packed {
        logic ovf;
        logic done;
        logic empty;
    } tx_event_t;

    function automatic int thr_free(input logic sel, input int depth);
        return sel ? depth : depth / 2;
    endfunction

endpackage

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [W-1:0]                   din,
    input  logic                           pop,
    output logic [W-1:0]                   dout,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty,
    output logic                           push_ok
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
    parameter int W     = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [W-1:0]     ld_data,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div,
    output logic             busy,
    output logic             last_step,
    output logic             sclk,
    output logic             mosi
);
    localparam int BW = $clog2(W);

    logic [W-1:0]     sreg;
    logic [DIV_W-1:0] div_cnt;
    logic [BW-1:0]    bit_cnt;
    logic             phase;   // 0 = idle-level half, 1 = active half
    logic             step;

    assign step      = busy && (div_cnt == div);
    assign last_step = step && phase && (bit_cnt == BW'(W-1));
    assign sclk      = cpol ^ (busy & phase);
    assign mosi      = busy ? sreg[W-1] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            phase   <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            sreg    <= '0;
        end else if (load && !busy) begin
            busy    <= 1'b1;
            phase   <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            sreg    <= ld_data;
        end else if (busy) begin
            if (step) begin
                div_cnt <= '0;
                if (!phase) begin
                    phase <= 1'b1;
                end else begin
                    phase <= 1'b0;
                    if (bit_cnt == BW'(W-1)) begin
                        busy <= 1'b0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        sreg    <= {sreg[W-2:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_tx_irq.sv
module spi_tx_irq
    import spi_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tx_event_t         ev,
    input  logic [STAT_N-1:0] clr,
    output logic              irq_empty,
    output logic              irq_end,
    output logic [STAT_N-1:0] status
);
    logic [STAT_N-1:0] ev_v;
    assign ev_v = ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_empty <= 1'b0;
            irq_end   <= 1'b0;
        end else begin
            irq_empty <= ev.empty;
            irq_end   <= ev.done;
        end
    end

    for (genvar i = 0; i < STAT_N; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst) begin
                status[i] <= 1'b0;
            end else begin
                status[i] <= (status[i] & ~clr[i]) | ev_v[i];
            end
        end
    end
endmodule

// File: rtl/spi_tx_core.sv
module spi_tx_core
    import spi_tx_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int DEPTH  = FIFO_DEPTH,
    parameter int DIV_W  = CLK_DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              seq_mode,
    input  logic              thr_sel,
    input  logic              cpol,
    input  logic              start,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [STAT_N-1:0] stat_clr,
    output logic              sclk,
    output logic              mosi,
    output logic              irq_empty,
    output logic              irq_end,
    output logic [STAT_N-1:0] status
);
    localparam int CW = $clog2(DEPTH+1);

    tx_mode_e          mode;
    logic [DATA_W-1:0] dreg;
    logic              dreg_v;
    logic              fifo_push, fifo_pop, fifo_push_ok;
    logic              fifo_full, fifo_empty;
    logic [DATA_W-1:0] fifo_dout;
    logic [CW-1:0]     fifo_count;
    logic              busy, last_step, load, src_valid;
    logic [DATA_W-1:0] ld_data;
    logic [CW:0]       free_now, thr_val;
    tx_event_t         ev;

    assign mode      = tx_mode_e'(seq_mode);
    assign src_valid = (mode == MODE_SEQ) ? !fifo_empty : dreg_v;
    assign load      = start && !busy && src_valid;
    assign ld_data   = (mode == MODE_SEQ) ? fifo_dout : dreg;
    assign fifo_push = wr_en && (mode == MODE_SEQ);
    assign fifo_pop  = load && (mode == MODE_SEQ);

    // Single-mode holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            dreg   <= '0;
            dreg_v <= 1'b0;
        end else if (mode == MODE_SINGLE) begin
            if (load) begin
                dreg_v <= 1'b0;
            end else if (wr_en && !dreg_v) begin
                dreg   <= wr_data;
                dreg_v <= 1'b1;
            end
        end
    end

    spi_tx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (fifo_push),
        .din     (wr_data),
        .pop     (fifo_pop),
        .dout    (fifo_dout),
        .count   (fifo_count),
        .full    (fifo_full),
        .empty   (fifo_empty),
        .push_ok (fifo_push_ok)
    );

    spi_tx_shifter #(.W(DATA_W), .DIV_W(DIV_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .ld_data   (ld_data),
        .cpol      (cpol),
        .div       (clk_div),
        .busy      (busy),
        .last_step (last_step),
        .sclk      (sclk),
        .mosi      (mosi)
    );

    // Event detection: upward crossing of the free-space threshold
    always_comb begin
        free_now = (CW+1)'(DEPTH) - {1'b0, fifo_count};
        thr_val  = (CW+1)'(thr_free(thr_sel, DEPTH));
        ev       = '0;
        if (mode == MODE_SEQ) begin
            ev.empty = fifo_pop && !fifo_push_ok && ((free_now + 1'b1) == thr_val);
            ev.ovf   = wr_en && fifo_full;
        end else begin
            ev.empty = load;
            ev.ovf   = wr_en && dreg_v;
        end
        ev.done = last_step && !src_valid;
    end

    spi_tx_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .clr       (stat_clr),
        .irq_empty (irq_empty),
        .irq_end   (irq_end),
        .status    (status)
    );
endmodule

// File: rtl/spi_tx_core_chk.sv
module spi_tx_core_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH+1)
) (
    input logic          clk,
    input logic          rst,
    input logic          seq_mode,
    input logic          cpol,
    input logic          start,
    input logic          wr_en,
    input logic          sclk,
    input logic          busy,
    input logic          load,
    input logic          dreg_v,
    input logic          fifo_full,
    input logic [CW-1:0] fifo_count,
    input logic          irq_empty,
    input logic          irq_end,
    input logic [2:0]    status
);
    p_idle_level_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cpol));

    p_single_load_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (!seq_mode && load) |=> irq_empty);

    p_single_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !seq_mode && dreg_v) |=> status[2]);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && seq_mode && fifo_full) |=> status[2]);

    p_end_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        irq_end |-> !busy);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!start && !busy) |=> !busy);

    p_end_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        irq_end |-> status[1]);

    p_empty_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        irq_empty |-> status[0]);

    p_empty_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        irq_empty |=> !irq_empty);

    p_end_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        irq_end |=> !irq_end);
endmodule

bind spi_tx_core spi_tx_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .seq_mode   (seq_mode),
    .cpol       (cpol),
    .start      (start),
    .wr_en      (wr_en),
    .sclk       (sclk),
    .busy       (busy),
    .load       (load),
    .dreg_v     (dreg_v),
    .fifo_full  (fifo_full),
    .fifo_count (fifo_count),
    .irq_empty  (irq_empty),
    .irq_end    (irq_end),
    .status     (status)
);

// File: tb/spi_tx_core_test.sv
module spi_tx_core_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       seq_mode = 1'b0;
    logic       thr_sel = 1'b0;
    logic       cpol = 1'b0;
    logic       start = 1'b0;
    logic [7:0] clk_div = 8'd1;
    logic [2:0] stat_clr = '0;
    logic       sclk, mosi, irq_empty, irq_end;
    logic [2:0] status;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_tx_core uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .seq_mode(seq_mode), .thr_sel(thr_sel), .cpol(cpol), .start(start),
        .clk_div(clk_div), .stat_clr(stat_clr), .sclk(sclk), .mosi(mosi),
        .irq_empty(irq_empty), .irq_end(irq_end), .status(status)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_emp = 0;
    int n_end = 0;
    int n_rx = 0;
    logic [7:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_half(input logic [7:0] d);
        return int'(d) + 1;
    endfunction

    function automatic int exp_seq_pulses(input int n, input bit thr);
        int t = thr ? 32 : 16;
        return (t > 32 - n) ? 1 : 0;
    endfunction

    // Serial monitor, sampled on the falling system clock edge
    logic       prev_sclk = 1'b0;
    logic       prev_emp = 1'b0;
    logic       prev_end = 1'b0;
    int         since = 0;
    int         bits = 0;
    bit         lead_pending = 1'b0;
    logic [7:0] sh = '0;

    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = sclk;
            since = 0;
            bits = 0;
            lead_pending = 1'b0;
            prev_emp = 1'b0;
            prev_end = 1'b0;
        end else begin
            since++;
            if (sclk != prev_sclk) begin
                if (sclk != cpol) begin
                    if (bits > 0) chk(since == exp_half(clk_div), "R2 idle-phase length", since, exp_half(clk_div));
                    sh = {sh[6:0], mosi};
                    bits++;
                    lead_pending = 1'b1;
                end else if (lead_pending) begin
                    chk(since == exp_half(clk_div), "R2 active-phase length", since, exp_half(clk_div));
                    lead_pending = 1'b0;
                    if (bits == 8) begin
                        bits = 0;
                        n_rx++;
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R5 unexpected byte", int'(sh), -1);
                        end else begin
                            automatic logic [7:0] e = exp_q.pop_front();
                            chk(sh == e, "R2 R5 byte value", int'(sh), int'(e));
                        end
                    end
                end
                since = 0;
            end
            prev_sclk = sclk;
            if (irq_empty) begin
                n_emp++;
                chk(!prev_emp, "R12 empty pulse width", 2, 1);
            end
            if (irq_end) begin
                n_end++;
                chk(bits == 0 && sclk == cpol, "R9 end after final edge", bits, 0);
                chk(!prev_end, "R12 end pulse width", 2, 1);
            end
            prev_emp = irq_empty;
            prev_end = irq_end;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic write_byte(input logic [7:0] b, input bit accepted);
        wr_data = b;
        wr_en = 1'b1;
        step();
        wr_en = 1'b0;
        if (accepted) exp_q.push_back(b);
    endtask

    task automatic wait_emp(input int target);
        while (n_emp < target) step();
    endtask

    task automatic wait_end(input int target);
        while (n_end < target) step();
    endtask

    task automatic clear_status();
        stat_clr = 3'b111;
        step();
        stat_clr = 3'b000;
    endtask

    task automatic single_run(input int n);
        int e0 = n_emp;
        int d0 = n_end;
        seq_mode = 1'b0;
        start = 1'b1;
        for (int i = 0; i < n; i++) begin
            write_byte(8'($urandom), 1'b1);
            wait_emp(e0 + i + 1);
        end
        wait_end(d0 + 1);
        step(3);
        chk(n_emp - e0 == n, "R3 empty pulses per load", n_emp - e0, n);
        chk(n_end - d0 == 1, "R9 one end per burst", n_end - d0, 1);
        chk(exp_q.size() == 0, "R2 all bytes sent", exp_q.size(), 0);
        start = 1'b0;
    endtask

    task automatic seq_run(input int n, input bit thr);
        int e0 = n_emp;
        int d0 = n_end;
        seq_mode = 1'b1;
        thr_sel = thr;
        start = 1'b0;
        for (int i = 0; i < n; i++) write_byte(8'($urandom), 1'b1);
        start = 1'b1;
        wait_end(d0 + 1);
        step(3);
        chk(n_emp - e0 == exp_seq_pulses(n, thr), thr ? "R7 drained threshold count" : "R6 half threshold count",
            n_emp - e0, exp_seq_pulses(n, thr));
        chk(exp_q.size() == 0, "R5 FIFO order and count", exp_q.size(), 0);
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int e0, d0, r0;
        void'($urandom(32'h5EED_0042));
        step(5);
        rst = 1'b0;
        step();
        // R1 reset state
        chk(sclk == 1'b0 && mosi == 1'b0, "R1 serial idle", {sclk, mosi}, 0);
        chk(!irq_empty && !irq_end, "R1 no pulses", {irq_empty, irq_end}, 0);
        chk(status == 3'b000, "R1 status clear", status, 0);

        // R3 single mode, cpol 0
        clk_div = 8'd2;
        single_run(6);

        // R10 and R4: start held low, second write dropped
        clear_status();
        e0 = n_emp; r0 = n_rx; d0 = n_end;
        write_byte(8'hA5, 1'b1);
        write_byte(8'h3C, 1'b0);
        chk(status == 3'b100, "R4 dropped write flagged", status, 4);
        step(60);
        chk(n_rx == r0 && n_emp == e0, "R10 nothing sent while start low", n_rx - r0, 0);
        chk(sclk == cpol, "R10 sclk idle", sclk, cpol);
        clear_status();
        chk(status == 3'b000, "R11 write-one-to-clear", status, 0);
        start = 1'b1;
        wait_end(d0 + 1);
        step(3);
        chk(n_rx - r0 == 1 && exp_q.size() == 0, "R4 only first byte sent", n_rx - r0, 1);
        chk(status == 3'b011, "R11 sticky set by pulses", status, 3);
        start = 1'b0;
        clear_status();

        // R8 and R6: full FIFO, overfill, refill by 16 on half threshold, cpol 1
        cpol = 1'b1;
        clk_div = 8'd1;
        seq_mode = 1'b1;
        thr_sel = 1'b0;
        step(2);
        e0 = n_emp; d0 = n_end;
        for (int i = 0; i < 32; i++) write_byte(8'($urandom), 1'b1);
        chk(status == 3'b000, "R8 32 bytes fit", status, 0);
        write_byte(8'hEE, 1'b0);
        chk(status == 3'b100, "R8 overfill flagged", status, 4);
        chk(n_emp == e0, "R6 no pulse while filling", n_emp - e0, 0);
        start = 1'b1;
        wait_emp(e0 + 1);
        for (int i = 0; i < 16; i++) write_byte(8'($urandom), 1'b1);
        wait_end(d0 + 1);
        step(3);
        chk(n_emp - e0 == 2, "R6 two half-threshold pulses", n_emp - e0, 2);
        chk(exp_q.size() == 0, "R5 48 bytes in order", exp_q.size(), 0);
        chk(sclk == 1'b1, "R9 cpol 1 rests high", sclk, 1);
        start = 1'b0;

        // R7 drained threshold, cpol 0, slower divider
        cpol = 1'b0;
        clk_div = 8'd3;
        step(2);
        seq_run(16, 1'b1);

        // Random rounds
        for (int r = 0; r < 6; r++) begin
            cpol = 1'($urandom);
            clk_div = 8'($urandom % 4);
            step(2);
            if (($urandom % 2) == 0) begin
                single_run(1 + int'($urandom % 5));
            end else begin
                seq_run(16 * (1 + int'($urandom % 2)), 1'($urandom));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule